// File: doc/BRIEF.md
# Split User/Supervisor Translation Buffer

This block caches virtual-to-physical page translations in two independent direct-mapped arrays. One serves user-mode accesses and the other serves supervisor-mode accesses. A lookup presents a virtual address, the access mode and a write flag. Within the same cycle it returns a hit indication, the physical frame number and the page attributes: read-only, cache-inhibit and modify state. A write to a page whose modify state is still clear is reported as a miss. The external page walker then handles the access and sets the modify bit.

The walker writes completed translations through a fill port, which takes effect at the next clock edge. Four invalidation scopes exist. A full flush clears both arrays. A user flush or a supervisor flush clears one array. A single-address purge clears the slot of that address in both arrays. Valid bits are held in flops, so every invalidation completes in one cycle. The array depth, the page size and the field widths are parameters.

Top module: `tlb_split`

## Requirements
- R1: After reset every entry in both arrays is invalid, so every lookup reports a miss.
- R2: After a fill, a lookup in the same mode at the same page reports a hit from the next cycle on, and returns the filled frame, read-only, cache-inhibit and modify values.
- R3: A fill to one mode's array never produces a hit for a lookup in the other mode.
- R4: Each array is direct-mapped. The slot is va[PAGE_W+IDX_W-1:PAGE_W], which is va[21:12] by default, and the tag is the remaining upper bits. A lookup whose tag differs from the stored tag misses, and a new fill to a slot replaces the old translation.
- R5: A full flush makes every entry of both arrays invalid at the next edge.
- R6: A user flush invalidates every user entry and leaves supervisor entries untouched.
- R7: A supervisor flush invalidates every supervisor entry and leaves user entries untouched.
- R8: A purge invalidates the slot selected by the purge address in both arrays, whatever tag is stored there. Other slots are unaffected.
- R9: A write lookup that matches an entry whose modify bit is 0 reports a miss. A read lookup of the same entry, or a write lookup of an entry whose modify bit is 1, reports a hit.
- R10: When a fill targets an array that is being flushed in the same cycle, or targets the slot being purged in the same cycle, the invalidation wins and the fill is dropped. A fill to any other slot alongside a purge still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_super | input | 1 | Lookup mode: 1 supervisor, 0 user |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Physical frame number of the matched entry |
| lk_ro | output | 1 | Read-only attribute of the matched entry |
| lk_ci | output | 1 | Cache-inhibit attribute of the matched entry |
| lk_dirty | output | 1 | Modify state of the matched entry |
| fill_en | input | 1 | Write a translation |
| fill_super | input | 1 | Fill target: 1 supervisor array, 0 user array |
| fill_va | input | VA_W | Virtual address of the filled translation |
| fill_pfn | input | PFN_W | Frame number to store |
| fill_ro | input | 1 | Read-only attribute to store |
| fill_ci | input | 1 | Cache-inhibit attribute to store |
| fill_dirty | input | 1 | Modify state to store |
| inv_all | input | 1 | Flush both arrays |
| inv_user | input | 1 | Flush the user array |
| inv_super | input | 1 | Flush the supervisor array |
| purge_en | input | 1 | Purge one slot in both arrays |
| purge_va | input | VA_W | Address whose slot is purged |

## Verification
The assertions assume that reset is held low from time zero until the first clock edges have passed. They also assume that lookup outputs are meaningful only while inputs are stable between edges. The bench drives every input on the falling edge and samples lookups one nanosecond later, so both conditions hold. It uses a 16-slot configuration, which lets each sweep cover every slot in both modes with both read and write lookups. It also issues fills and invalidations together in the same cycle, so that the priority assertions are exercised.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic {
      MODE_USER  = 1'b0,
      MODE_SUPER = 1'b1
   } tlb_mode_e;

   localparam int N_MODES = 2;

   typedef struct packed {
      logic ro;
      logic ci;
      logic dirty;
   } tlb_attr_t;
endpackage

// File: rtl/tlb_inv_ctl.sv
module tlb_inv_ctl
   import tlb_pkg::*;
(
   input  logic               inv_all,
   input  logic               inv_user,
   input  logic               inv_super,
   output logic [N_MODES-1:0] bank_clr
);
   always_comb begin
      bank_clr             = '0;
      bank_clr[MODE_USER]  = inv_all | inv_user;
      bank_clr[MODE_SUPER] = inv_all | inv_super;
   end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
   import tlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PAGE_W = 12,
   parameter int IDX_W  = 10,
   parameter int PFN_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VA_W-1:0]  lk_va,
   input  logic             lk_write,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output tlb_attr_t        lk_attr,
   input  logic             fill_en,
   input  logic [VA_W-1:0]  fill_va,
   input  logic [PFN_W-1:0] fill_pfn,
   input  tlb_attr_t        fill_attr,
   input  logic             clr,
   input  logic             purge_en,
   input  logic [VA_W-1:0]  purge_va
);
   localparam int TAG_W = VA_W - PAGE_W - IDX_W;
   localparam int DEPTH = 1 << IDX_W;
   localparam int TAG_LO = PAGE_W + IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [TAG_W-1:0] tag_m  [DEPTH];
   logic [PFN_W-1:0] pfn_m  [DEPTH];
   tlb_attr_t        attr_m [DEPTH];

   logic [IDX_W-1:0] lk_idx, fill_idx, purge_idx;
   logic [TAG_W-1:0] lk_tag, fill_tag;
   logic             fill_ok, ent_match;

   assign lk_idx    = lk_va[TAG_LO-1:PAGE_W];
   assign fill_idx  = fill_va[TAG_LO-1:PAGE_W];
   assign purge_idx = purge_va[TAG_LO-1:PAGE_W];
   assign lk_tag    = lk_va[VA_W-1:TAG_LO];
   assign fill_tag  = fill_va[VA_W-1:TAG_LO];

   // invalidation outranks a fill aimed at the same slot
   assign fill_ok = fill_en && !clr && !(purge_en && (purge_idx == fill_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (clr) begin
         vld_q <= '0;
      end else begin
         if (fill_ok)  vld_q[fill_idx]  <= 1'b1;
         if (purge_en) vld_q[purge_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_ok) begin
         tag_m[fill_idx]  <= fill_tag;
         pfn_m[fill_idx]  <= fill_pfn;
         attr_m[fill_idx] <= fill_attr;
      end
   end

   assign ent_match = vld_q[lk_idx] && (tag_m[lk_idx] == lk_tag);
   assign lk_hit    = ent_match && !(lk_write && !attr_m[lk_idx].dirty);
   assign lk_pfn    = pfn_m[lk_idx];
   assign lk_attr   = attr_m[lk_idx];

   p_clr_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld_q == '0));

   p_purge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      purge_en |=> !vld_q[$past(purge_idx)]);

   p_fill_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !clr && !purge_en) |=> vld_q[$past(fill_idx)]);

   p_inv_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && (clr || (purge_en && purge_idx == fill_idx))) |=> !vld_q[$past(fill_idx)]);
endmodule

// File: rtl/tlb_split.sv
module tlb_split
   import tlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PAGE_W = 12,
   parameter int IDX_W  = 10,
   parameter int PFN_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VA_W-1:0]  lk_va,
   input  logic             lk_super,
   input  logic             lk_write,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_ro,
   output logic             lk_ci,
   output logic             lk_dirty,
   input  logic             fill_en,
   input  logic             fill_super,
   input  logic [VA_W-1:0]  fill_va,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_ro,
   input  logic             fill_ci,
   input  logic             fill_dirty,
   input  logic             inv_all,
   input  logic             inv_user,
   input  logic             inv_super,
   input  logic             purge_en,
   input  logic [VA_W-1:0]  purge_va
);
   if (IDX_W < 1 || PAGE_W < 1 || PFN_W < 1) begin : g_bad_width
      $error("tlb_split: IDX_W, PAGE_W and PFN_W must be positive");
   end
   if (VA_W <= PAGE_W + IDX_W) begin : g_bad_va
      $error("tlb_split: VA_W must leave at least one tag bit");
   end

   logic [N_MODES-1:0] bank_clr;
   logic [N_MODES-1:0] b_hit;
   logic [PFN_W-1:0]   b_pfn  [N_MODES];
   tlb_attr_t          b_attr [N_MODES];
   tlb_attr_t          fill_attr;

   assign fill_attr = '{ro: fill_ro, ci: fill_ci, dirty: fill_dirty};

   tlb_inv_ctl i_inv (
      .inv_all  (inv_all),
      .inv_user (inv_user),
      .inv_super(inv_super),
      .bank_clr (bank_clr)
   );

   for (genvar b = 0; b < N_MODES; b++) begin : g_bank
      tlb_bank #(
         .VA_W  (VA_W),
         .PAGE_W(PAGE_W),
         .IDX_W (IDX_W),
         .PFN_W (PFN_W)
      ) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_va    (lk_va),
         .lk_write (lk_write),
         .lk_hit   (b_hit[b]),
         .lk_pfn   (b_pfn[b]),
         .lk_attr  (b_attr[b]),
         .fill_en  (fill_en && (fill_super == b[0])),
         .fill_va  (fill_va),
         .fill_pfn (fill_pfn),
         .fill_attr(fill_attr),
         .clr      (bank_clr[b]),
         .purge_en (purge_en),
         .purge_va (purge_va)
      );
   end

   assign lk_hit   = b_hit[lk_super];
   assign lk_pfn   = b_pfn[lk_super];
   assign lk_ro    = b_attr[lk_super].ro;
   assign lk_ci    = b_attr[lk_super].ci;
   assign lk_dirty = b_attr[lk_super].dirty;

   // R9: a reported write hit always carries a set modify bit
   p_write_hit_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write) |-> lk_dirty);

   // R5: the full flush empties both arrays, so the next cycle misses
   p_flush_all_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fill_en) |=> !b_hit[0] && !b_hit[1]);
endmodule

// File: tb/test_tlb_split.sv
`timescale 1ns/1ps
module test_tlb_split;
   localparam int VA_W = 32, PAGE_W = 12, IDX_W = 4, PFN_W = 20;
   localparam int NS = 1 << IDX_W;
   localparam int TAG_W = VA_W - PAGE_W - IDX_W;

   logic clk = 0, rst_n = 0;
   logic [VA_W-1:0] lk_va = '0, fill_va = '0, purge_va = '0;
   logic lk_super = 0, lk_write = 0, fill_en = 0, fill_super = 0;
   logic [PFN_W-1:0] fill_pfn = '0;
   logic fill_ro = 0, fill_ci = 0, fill_dirty = 0;
   logic inv_all = 0, inv_user = 0, inv_super = 0, purge_en = 0;
   logic lk_hit, lk_ro, lk_ci, lk_dirty;
   logic [PFN_W-1:0] lk_pfn;

   int n_checks = 0, n_errors = 0;

   bit              mv   [2][NS];
   logic [TAG_W-1:0] mtag [2][NS];
   logic [PFN_W-1:0] mpfn [2][NS];
   logic [2:0]       mattr[2][NS];

   always #4 clk = ~clk;

   tlb_split #(.VA_W(VA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .PFN_W(PFN_W)) i_tlb_split (
      .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_super(lk_super), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_ro(lk_ro), .lk_ci(lk_ci), .lk_dirty(lk_dirty),
      .fill_en(fill_en), .fill_super(fill_super), .fill_va(fill_va), .fill_pfn(fill_pfn),
      .fill_ro(fill_ro), .fill_ci(fill_ci), .fill_dirty(fill_dirty),
      .inv_all(inv_all), .inv_user(inv_user), .inv_super(inv_super),
      .purge_en(purge_en), .purge_va(purge_va));

   function automatic logic [VA_W-1:0] mkva(logic [TAG_W-1:0] t, int idx);
      return {t, idx[IDX_W-1:0], 12'h5a3};
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic look(bit s, logic [VA_W-1:0] va, bit w, string req);
      int idx;
      bit eh;
      idx = int'(va[PAGE_W+IDX_W-1:PAGE_W]);
      lk_va = va; lk_super = s; lk_write = w;
      #1;
      eh = mv[s][idx] && mtag[s][idx] == va[VA_W-1:PAGE_W+IDX_W] && !(w && !mattr[s][idx][0]);
      check(req, 64'(lk_hit), 64'(eh), "hit");
      if (eh) check(req, {41'd0, lk_pfn, lk_ro, lk_ci, lk_dirty},
                    {41'd0, mpfn[s][idx], mattr[s][idx]}, "pfn/attr");
   endtask

   // one clock: drive at falling edge, model applied after the rising edge
   task automatic step(bit fe, bit fs, logic [VA_W-1:0] fva, logic [PFN_W-1:0] fp, logic [2:0] fa,
                       bit ia, bit iu, bit is, bit pe, logic [VA_W-1:0] pva);
      int fi, pi;
      bit clr [2];
      fill_en = fe; fill_super = fs; fill_va = fva; fill_pfn = fp;
      {fill_ro, fill_ci, fill_dirty} = fa;
      inv_all = ia; inv_user = iu; inv_super = is; purge_en = pe; purge_va = pva;
      @(posedge clk); @(negedge clk);
      fill_en = 0; inv_all = 0; inv_user = 0; inv_super = 0; purge_en = 0;
      fi = int'(fva[PAGE_W+IDX_W-1:PAGE_W]);
      pi = int'(pva[PAGE_W+IDX_W-1:PAGE_W]);
      clr[0] = ia | iu; clr[1] = ia | is;
      for (int m = 0; m < 2; m++) begin
         if (clr[m]) for (int k = 0; k < NS; k++) mv[m][k] = 0;
         if (pe) mv[m][pi] = 0;
      end
      if (fe && !clr[fs] && !(pe && pi == fi)) begin
         mv[fs][fi] = 1; mtag[fs][fi] = fva[VA_W-1:PAGE_W+IDX_W];
         mpfn[fs][fi] = fp; mattr[fs][fi] = fa;
      end
   endtask

   task automatic fill(bit s, logic [VA_W-1:0] va, logic [PFN_W-1:0] p, logic [2:0] a);
      step(1, s, va, p, a, 0, 0, 0, 0, '0);
   endtask

   // every slot, both modes, read and write, using each mode's modelled tag
   task automatic sweep(string req);
      for (int m = 0; m < 2; m++)
         for (int k = 0; k < NS; k++) begin
            look(m[0], mkva(mtag[m][k], k), 0, req);
            look(m[0], mkva(mtag[m][k], k), 1, req);
            look(!m[0], mkva(mtag[m][k], k), 0, req);
         end
   endtask

   initial begin
      #(8 * 200000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      for (int m = 0; m < 2; m++)
         for (int k = 0; k < NS; k++) begin
            mv[m][k] = 0; mtag[m][k] = TAG_W'(k + 1); mpfn[m][k] = '0; mattr[m][k] = '0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1;
      sweep("R1");
      // R2 R3 R9: user array full, supervisor still empty
      for (int k = 0; k < NS; k++)
         fill(0, mkva(TAG_W'(k + 1), k), PFN_W'(k * 7 + 3), 3'(k));
      sweep("R2_R3_R9");
      for (int k = 0; k < NS; k++)
         fill(1, mkva(TAG_W'(k + 40), k), PFN_W'(k * 11 + 5), 3'(7 - k));
      sweep("R2_R3_R9");
      // R4: tag mismatch and replacement
      look(0, mkva(TAG_W'(999), 5), 0, "R4");
      fill(0, mkva(TAG_W'(999), 5), PFN_W'(20'hABCDE), 3'b101);
      look(0, mkva(TAG_W'(6), 5), 0, "R4");
      look(0, mkva(TAG_W'(999), 5), 0, "R4");
      // R8: purge slot 3 with an unrelated tag
      step(0, 0, '0, '0, '0, 0, 0, 0, 1, mkva(TAG_W'(77), 3));
      sweep("R8");
      // R6, R7, R5
      step(0, 0, '0, '0, '0, 0, 1, 0, 0, '0);
      sweep("R6");
      for (int k = 0; k < NS; k += 3) fill(0, mkva(TAG_W'(k + 2), k), PFN_W'(k + 100), 3'b001);
      step(0, 0, '0, '0, '0, 0, 0, 1, 0, '0);
      sweep("R7");
      for (int k = 0; k < NS; k += 2) fill(1, mkva(TAG_W'(k + 9), k), PFN_W'(k + 200), 3'b011);
      step(0, 0, '0, '0, '0, 1, 0, 0, 0, '0);
      sweep("R5");
      // R10: fill against flush and purge in the same cycle
      step(1, 0, mkva(TAG_W'(3), 2), PFN_W'(1), 3'b001, 0, 1, 0, 0, '0);
      look(0, mkva(TAG_W'(3), 2), 0, "R10");
      step(1, 1, mkva(TAG_W'(4), 6), PFN_W'(2), 3'b001, 0, 0, 0, 1, mkva(TAG_W'(50), 6));
      look(1, mkva(TAG_W'(4), 6), 0, "R10");
      step(1, 1, mkva(TAG_W'(4), 7), PFN_W'(3), 3'b001, 0, 0, 0, 1, mkva(TAG_W'(50), 8));
      look(1, mkva(TAG_W'(4), 7), 0, "R10");
      step(1, 1, mkva(TAG_W'(5), 9), PFN_W'(4), 3'b001, 0, 1, 0, 0, '0);
      look(1, mkva(TAG_W'(5), 9), 0, "R10");
      sweep("R10");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule